// File: doc/BRIEF.md
# Interrupt Priority and Delegation Selector

This block decides, each cycle, whether the hart must take an interrupt now and which one. It takes the pending and enable vectors, the delegation mask, the current privilege level and the machine and supervisor global interrupt-enable bits. A pending interrupt is a candidate only when it is also enabled. Each candidate is gated by its own handler level. An interrupt that is not delegated goes to machine level. A delegated interrupt goes to supervisor level. Each is eligible only when the hart runs below that level, or at that level with the matching global enable set.

Among the eligible interrupts, the lowest bit index wins. The block outputs a take strobe and an XLEN-wide cause word. The cause word holds the winning index in its low bits and has its top bit set to flag an interrupt. Only the seven implemented sources are considered: supervisor and machine software, timer and external interrupts, and one coprocessor line. Other bits of the vectors are ignored. A parameter chooses how the outputs are produced. They are either combinational, or registered once with an asynchronous active-low reset.

Top module: `irq_select`

## Requirements
- R1: An interrupt is a candidate only when its pending bit and its enable bit are both 1; a pending but disabled line is never taken.
- R2: A candidate whose delegation bit is 0 is eligible when the privilege input (user = 2'b00, supervisor = 2'b01, machine = 2'b11) is below machine, or is machine with the machine global enable set.
- R3: A candidate whose delegation bit is 1 is eligible when the privilege input is user, or is supervisor with the supervisor global enable set; it is never eligible at machine level.
- R4: When several interrupts are eligible, the lowest bit index is selected, whether it is delegated or not.
- R5: When an interrupt is taken, the cause word bit XLEN-1 is 1, bits [3:0] hold the winning index and all other bits are 0; this holds for XLEN of 32 and of 64.
- R6: With no eligible interrupt, take_o is 0 and cause_o is all zeros.
- R7: Only bit positions 1, 3, 5, 7, 9, 11 and 12 are implemented sources; pending or enable bits at any other position never cause a take.
- R8: With REG_OUT = 1, the outputs show the decision for the inputs present at the previous rising clock edge, and are 0 while rst_ni is low; with REG_OUT = 0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used by the registered variant |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | IRQ_W | Pending interrupt vector |
| en_i | input | IRQ_W | Per-interrupt enable vector |
| deleg_i | input | IRQ_W | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege level |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | Take an interrupt now |
| cause_o | output | XLEN | Cause word with the interrupt flag in the top bit |

## Verification
The assertions assume that the privilege input never carries the reserved value 2. Its eligibility is not defined here, so a checker flags that value as an input violation. The bench draws privilege only from user, supervisor and machine. It sweeps the pending, enable and delegation vectors at random across all sixteen bit positions, so the unimplemented positions are exercised as well. It also runs directed cases at each level boundary, with each global enable both set and clear.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned IRQ_SSW  = 1;
  localparam int unsigned IRQ_MSW  = 3;
  localparam int unsigned IRQ_STMR = 5;
  localparam int unsigned IRQ_MTMR = 7;
  localparam int unsigned IRQ_SEXT = 9;
  localparam int unsigned IRQ_MEXT = 11;
  localparam int unsigned IRQ_COP  = 12;

  localparam int unsigned MIN_IRQ_W = IRQ_COP + 1;

  function automatic logic [63:0] impl_mask();
    logic [63:0] m;
    m = '0;
    m[IRQ_SSW]  = 1'b1;
    m[IRQ_MSW]  = 1'b1;
    m[IRQ_STMR] = 1'b1;
    m[IRQ_MTMR] = 1'b1;
    m[IRQ_SEXT] = 1'b1;
    m[IRQ_MEXT] = 1'b1;
    m[IRQ_COP]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_elig.sv
module irq_elig #(
  parameter int unsigned IRQ_W = 16
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] en_i,
  input  logic [IRQ_W-1:0] deleg_i,
  input  logic [IRQ_W-1:0] impl_i,
  input  logic [1:0]       priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  output logic [IRQ_W-1:0] elig_o
);
  import irq_select_pkg::*;

  logic m_open, s_open;

  // handler level open when running below it, or at it with its global enable
  assign m_open = (priv_i != PRIV_M) || m_gie_i;
  assign s_open = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    logic cand;
    assign cand      = pend_i[i] & en_i[i] & impl_i[i];
    assign elig_o[i] = cand & (deleg_i[i] ? s_open : m_open);
  end

endmodule

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
  parameter int unsigned IRQ_W = 16,
  localparam int unsigned IDX_W = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = IRQ_W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/irq_cause_out.sv
module irq_cause_out #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IDX_W   = 4,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             take_o,
  output logic [XLEN-1:0]  cause_o
);

  logic [XLEN-1:0] cause_d;

  always_comb begin
    cause_d = '0;
    if (any_i) begin
      cause_d[IDX_W-1:0] = idx_i;
      cause_d[XLEN-1]    = 1'b1;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        take_o  <= 1'b0;
        cause_o <= '0;
      end else begin
        take_o  <= any_i;
        cause_o <= cause_d;
      end
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign take_o  = any_i;
    assign cause_o = cause_d;
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IRQ_W   = 16,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] en_i,
  input  logic [IRQ_W-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  output logic             take_o,
  output logic [XLEN-1:0]  cause_o
);
  import irq_select_pkg::*;

  localparam int unsigned IDX_W = $clog2(IRQ_W);
  localparam logic [63:0] IMPL_ALL = impl_mask();
  localparam logic [IRQ_W-1:0] IMPL = IMPL_ALL[IRQ_W-1:0];

  logic [IRQ_W-1:0] elig;
  logic             any;
  logic [IDX_W-1:0] idx;

  irq_elig #(.IRQ_W(IRQ_W)) u_elig (
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .impl_i  (IMPL),
    .priv_i  (priv_i),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .elig_o  (elig)
  );

  irq_lowest_first #(.IRQ_W(IRQ_W)) u_pick (
    .req_i (elig),
    .any_o (any),
    .idx_o (idx)
  );

  irq_cause_out #(.XLEN(XLEN), .IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .any_i   (any),
    .idx_i   (idx),
    .take_o  (take_o),
    .cause_o (cause_o)
  );

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IRQ_W   = 16,
  parameter bit          REG_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IRQ_W-1:0] pend_i,
  input logic [IRQ_W-1:0] en_i,
  input logic [IRQ_W-1:0] deleg_i,
  input logic [1:0]       priv_i,
  input logic             m_gie_i,
  input logic             s_gie_i,
  input logic             take_o,
  input logic [XLEN-1:0]  cause_o
);
  localparam int unsigned IDX_W = $clog2(IRQ_W);
  localparam logic [XLEN-1:0] IDX_FIELD = XLEN'((1 << IDX_W) - 1);
  localparam logic [XLEN-1:0] FLAG = {1'b1, {(XLEN-1){1'b0}}};

  // inputs aligned with the cycle the outputs belong to
  logic [IRQ_W-1:0] a_pend, a_en, a_deleg;
  logic [1:0]       a_priv;
  logic             a_mgie;

  if (REG_OUT) begin : g_align
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_pend <= '0; a_en <= '0; a_deleg <= '0; a_priv <= 2'b00; a_mgie <= 1'b0;
      end else begin
        a_pend <= pend_i; a_en <= en_i; a_deleg <= deleg_i;
        a_priv <= priv_i; a_mgie <= m_gie_i;
      end
    end
  end else begin : g_same
    assign a_pend = pend_i; assign a_en = en_i; assign a_deleg = deleg_i;
    assign a_priv = priv_i; assign a_mgie = m_gie_i;
  end

  logic [IDX_W-1:0] win;
  assign win = cause_o[IDX_W-1:0];

  logic unused_sgie;
  assign unused_sgie = s_gie_i;

  assert_priv_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_i != 2'b10);

  assert_winner_enabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (a_pend[win] && a_en[win]));

  assert_machine_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_priv == 2'b11 && !a_mgie) |-> !take_o);

  assert_no_deleg_at_m_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && a_priv == 2'b11) |-> !a_deleg[win]);

  assert_cause_form_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (cause_o[XLEN-1] && ((cause_o & ~(FLAG | IDX_FIELD)) == '0)));

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cause_o == '0));

  assert_impl_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (win == 1 || win == 3 || win == 5 || win == 7 || win == 9 ||
                win == 11 || win == 12));

endmodule

bind irq_select irq_select_chk #(.XLEN(XLEN), .IRQ_W(IRQ_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pend_i  (pend_i),
  .en_i    (en_i),
  .deleg_i (deleg_i),
  .priv_i  (priv_i),
  .m_gie_i (m_gie_i),
  .s_gie_i (s_gie_i),
  .take_o  (take_o),
  .cause_o (cause_o)
);

// File: tb/test_irq_select.sv
`timescale 1ns/1ps
module test_irq_select;
  localparam int unsigned W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  pend = '0, en = '0, deleg = '0;
  logic [1:0]    priv = 2'b11;
  logic          mgie = 1'b0, sgie = 1'b0;
  logic          take32, take64;
  logic [31:0]   cause32;
  logic [63:0]   cause64;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  // combinational variant, XLEN 32
  irq_select #(.XLEN(32), .IRQ_W(W), .REG_OUT(1'b0)) i_irq_select (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie), .take_o(take32), .cause_o(cause32));

  // registered variant, XLEN 64
  irq_select #(.XLEN(64), .IRQ_W(W), .REG_OUT(1'b1)) i_irq_select_w64 (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie), .take_o(take64), .cause_o(cause64));

  localparam logic [W-1:0] IMPL = 16'h1AAA; // bits 1,3,5,7,9,11,12

  // reference: returns -1 when nothing is eligible
  function automatic int ref_idx(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] d,
                                 logic [1:0] pv, logic mg, logic sg);
    bit m_ok = (pv < 2'd3) || mg;
    bit s_ok = (pv < 2'd1) || (pv == 2'd1 && sg);
    for (int i = 0; i < W; i++) begin
      if (p[i] && e[i] && IMPL[i] && (d[i] ? s_ok : m_ok)) return i;
    end
    return -1;
  endfunction

  task automatic drive(logic [W-1:0] p, logic [W-1:0] e, logic [W-1:0] d,
                       logic [1:0] pv, logic mg, logic sg);
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pv; mgie = mg; sgie = sg;
    @(posedge clk);
    #1;
  endtask

  task automatic check_exp(string tag, int exp);
    logic [31:0] e32 = (exp < 0) ? 32'd0 : (32'h8000_0000 | 32'(exp));
    logic [63:0] e64 = (exp < 0) ? 64'd0 : (64'h8000_0000_0000_0000 | 64'(exp));
    bit et = (exp >= 0);
    n_chk++;
    if (take32 !== et || cause32 !== e32) begin
      n_bad++;
      $display("FAIL %s x32: take=%0b cause=%h expected take=%0b cause=%h", tag, take32, cause32, et, e32);
    end
    n_chk++;
    if (take64 !== et || cause64 !== e64) begin
      n_bad++;
      $display("FAIL %s x64: take=%0b cause=%h expected take=%0b cause=%h", tag, take64, cause64, et, e64);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: registered output stays zero in reset even with an eligible input
    pend = 16'h0080; en = 16'h0080; priv = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (take64 !== 1'b0 || cause64 !== 64'd0) begin
      n_bad++;
      $display("FAIL R8 reset: take=%0b cause=%h expected take=0 cause=0", take64, cause64);
    end
    n_chk++; // R8: comb variant follows inputs even in reset
    if (take32 !== 1'b1 || cause32 !== 32'h8000_0007) begin
      n_bad++;
      $display("FAIL R8 comb: take=%0b cause=%h expected take=1 cause=80000007", take32, cause32);
    end
    @(negedge clk); rst_n = 1'b1;

    drive(16'h0000, 16'hFFFF, 16'h0000, 2'b11, 1, 1); check_exp("R6 nothing pending", -1);
    drive(16'h0080, 16'h0000, 16'h0000, 2'b00, 1, 1); check_exp("R1 pending not enabled", -1);
    drive(16'h0080, 16'hFF7F, 16'h0000, 2'b00, 1, 1); check_exp("R1 other enables only", -1);
    drive(16'h0080, 16'h0080, 16'h0000, 2'b11, 0, 1); check_exp("R2 M level gie off", -1);
    drive(16'h0080, 16'h0080, 16'h0000, 2'b11, 1, 0); check_exp("R2 M level gie on", 7);
    drive(16'h0080, 16'h0080, 16'h0000, 2'b01, 0, 0); check_exp("R2 S level below M", 7);
    drive(16'h0080, 16'h0080, 16'h0000, 2'b00, 0, 0); check_exp("R2 U level below M", 7);
    drive(16'h0020, 16'h0020, 16'h0020, 2'b11, 1, 1); check_exp("R3 delegated at M", -1);
    drive(16'h0020, 16'h0020, 16'h0020, 2'b01, 1, 0); check_exp("R3 S level gie off", -1);
    drive(16'h0020, 16'h0020, 16'h0020, 2'b01, 0, 1); check_exp("R3 S level gie on", 5);
    drive(16'h0020, 16'h0020, 16'h0020, 2'b00, 0, 0); check_exp("R3 U level below S", 5);
    drive(16'h100A, 16'hFFFF, 16'h0000, 2'b00, 0, 0); check_exp("R4 lowest of 1,3,12", 1);
    drive(16'h0882, 16'hFFFF, 16'h0002, 2'b11, 1, 1); check_exp("R4 delegated low bit masked at M", 7);
    drive(16'h0A00, 16'hFFFF, 16'h0200, 2'b00, 0, 0); check_exp("R4 delegated lower wins at U", 9);
    drive(16'h1000, 16'h1000, 16'h0000, 2'b11, 1, 0); check_exp("R5 coprocessor cause", 12);
    drive(16'h0800, 16'h0800, 16'h0000, 2'b01, 0, 0); check_exp("R5 external cause", 11);
    drive(16'hE555, 16'hFFFF, 16'h0000, 2'b00, 1, 1); check_exp("R7 unimplemented bits only", -1);
    drive(16'h8004, 16'hFFFF, 16'h8004, 2'b00, 1, 1); check_exp("R7 unimplemented delegated", -1);

    // R8: registered output lags one cycle behind the inputs
    @(negedge clk); pend = 16'h0008; en = 16'h0008; deleg = '0; priv = 2'b00;
    #1;
    n_chk++;
    if (take64 !== 1'b0 || cause64 !== 64'd0 || cause32 !== 32'h8000_0003) begin
      n_bad++;
      $display("FAIL R8 lag: take64=%0b cause64=%h cause32=%h expected 0 / 0 / 80000003",
               take64, cause64, cause32);
    end
    @(posedge clk); #1;
    check_exp("R8 after edge", 3);

    // R2 R3 R4 sweep over random vectors and legal levels
    for (int k = 0; k < 6000; k++) begin
      logic [1:0] pv;
      case ($urandom_range(2)) 0: pv = 2'b00; 1: pv = 2'b01; default: pv = 2'b11; endcase
      begin
        logic [W-1:0] p = W'($urandom), e = W'($urandom), d = W'($urandom);
        logic mg = 1'($urandom), sg = 1'($urandom);
        drive(p, e, d, pv, mg, sg);
        check_exp("R2/R3/R4 sweep", ref_idx(p, e, d, pv, mg, sg));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule